// File: doc/BRIEF.md
# Parallel SCSI Initiator Bus-Control Register Core

This block gives a host processor direct, register-level control over the control and data lines of a parallel SCSI bus. Through eight byte-wide addresses the host writes an output data byte, an initiator command byte, a mode byte, a target command byte and a select-enable mask. It reads back the live bus lines, a bus-and-status flag byte and a byte latched from the bus during a handshake. A single interrupt output reports selection attempts, parity failures on latched bytes and unexpected loss of BSY.

Every bus input passes through a two-flop synchronizer before it is compared, latched or read. The bus-side outputs are active-high assert requests for open-drain drivers outside the block, plus an enable for the data byte and its parity bit. The block arbitrates in a simple way. With arbitration requested, it takes the bus on the first cycle that BSY is seen free. It records a loss when another device raises SEL afterwards. Arbitration delay timing is left to host software.

Top module: `scsi_ini_regcore`

## Requirements
- R1: After reset every register, flag and interrupt is 0, no control line is asserted and the data enable is low.
- R2: A write to address 0 loads the output byte and a write to address 4 loads the select-enable mask. A write to address 2 loads the mode byte and a write to address 3 loads the low four bits of the target command. A write to address 1 stores initiator command bits 7 and 4..0, and bits 6..5 of that write are dropped. Writes to addresses 5, 6 and 7 change nothing. Reads of 1, 2 and 3 return the stored values. Address 3 reads with bits 7..4 at 0, and address 1 reads with bit 6 = arbitration in progress and bit 5 = arbitration lost.
- R3: A bus input change is visible on reads after exactly two clock edges. Address 0 returns the data lines. Address 4 returns {RST, BSY, REQ, MSG, C/D, I/O, SEL, DBP} from bit 7 down to bit 0.
- R4: Address 5 returns {0, 0, parity error, interrupt, phase match, busy error, ATN, ACK} from bit 7 down to bit 0. Phase match is 1 when the synchronized {MSG, C/D, I/O} equals target command bits 2..0.
- R5: The RST, ACK, SEL and ATN assert outputs follow initiator command bits 7, 4, 2 and 1. With mode bit 6 (target) set, the REQ, MSG, C/D and I/O outputs follow target command bits 3..0; otherwise they are 0.
- R6: The data outputs carry the output byte, and the parity output makes the total count of ones odd. The data enable is high when mode bit 0 (arbitrate) is set, or when initiator command bit 0 is set and phase match holds.
- R7: While mode bit 0 is set, arbitration-in-progress sets on the first edge at which synchronized BSY is 0, and the BSY output is asserted while it holds (or when command bit 3 is set). Arbitration-lost sets on an edge where arbitration is in progress, synchronized SEL is 1 and command bit 2 is 0. Clearing mode bit 0 clears both.
- R8: On a synchronized falling edge of REQ (mode bit 6 = 0) or of ACK (mode bit 6 = 1), the synchronized data byte is captured and read at address 6. The other line's falling edge captures nothing.
- R9: When mode bit 5 is set, a capture with an even count of ones over data and DBP sets the parity-error flag. With mode bit 4 also set, it raises the interrupt.
- R10: The interrupt is raised on any edge at which synchronized BSY is 0, SEL is 1 and a data line enabled in the select-enable mask is 1.
- R11: With mode bit 2 set, a synchronized BSY transition from 1 to 0 sets the busy-error flag and raises the interrupt.
- R12: The interrupt output is registered. A read of address 7 returns 0 and clears the interrupt, parity-error and busy-error flags at the next edge; an event on that same edge still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 3 | Register address |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe, side effect only at address 7 |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for cpu_addr |
| irq | output | 1 | Interrupt request |
| bus_rst_i | input | 1 | RST line active |
| bus_bsy_i | input | 1 | BSY line active |
| bus_sel_i | input | 1 | SEL line active |
| bus_atn_i | input | 1 | ATN line active |
| bus_ack_i | input | 1 | ACK line active |
| bus_req_i | input | 1 | REQ line active |
| bus_msg_i | input | 1 | MSG line active |
| bus_cd_i | input | 1 | C/D line active |
| bus_io_i | input | 1 | I/O line active |
| bus_db_i | input | 8 | Data lines, 1 = active |
| bus_dbp_i | input | 1 | Data parity line |
| drv_rst_o | output | 1 | Assert RST |
| drv_bsy_o | output | 1 | Assert BSY |
| drv_sel_o | output | 1 | Assert SEL |
| drv_atn_o | output | 1 | Assert ATN |
| drv_ack_o | output | 1 | Assert ACK |
| drv_req_o | output | 1 | Assert REQ (target mode) |
| drv_msg_o | output | 1 | Assert MSG (target mode) |
| drv_cd_o | output | 1 | Assert C/D (target mode) |
| drv_io_o | output | 1 | Assert I/O (target mode) |
| drv_db_o | output | 8 | Data byte to drive |
| drv_dbp_o | output | 1 | Odd parity of drv_db_o |
| drv_db_en_o | output | 1 | Drive enable for data and parity |

## Verification
A corrupted command, mode or target command register shows up at the assert outputs and the data enable in the same cycle, because those outputs decode the registers without further flops. Faults in the synchronizer or the edge detectors show up two or three edges after a bus change: the status or captured-data reads come out wrong, or shifted by a cycle. A wrong flag or a set/clear priority error reaches the interrupt pin one edge after the causing event and is visible at address 5 in the same cycle. The bench therefore compares every output against a behavioural model on every cycle, so that any single-cycle deviation is caught.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;

  localparam int DW = 8;
  localparam int AW = 3;

  // register addresses (read / write meaning differs per address)
  localparam logic [AW-1:0] ADR_DATA  = 3'd0;
  localparam logic [AW-1:0] ADR_ICMD  = 3'd1;
  localparam logic [AW-1:0] ADR_MODE  = 3'd2;
  localparam logic [AW-1:0] ADR_TCMD  = 3'd3;
  localparam logic [AW-1:0] ADR_STAT  = 3'd4;
  localparam logic [AW-1:0] ADR_BSTAT = 3'd5;
  localparam logic [AW-1:0] ADR_IDATA = 3'd6;
  localparam logic [AW-1:0] ADR_CLRI  = 3'd7;

  // initiator command bit positions
  localparam int IC_DATA = 0;
  localparam int IC_ATN  = 1;
  localparam int IC_SEL  = 2;
  localparam int IC_BSY  = 3;
  localparam int IC_ACK  = 4;
  localparam int IC_LOST = 5;
  localparam int IC_PROG = 6;
  localparam int IC_RST  = 7;
  localparam logic [DW-1:0] IC_STORE_MASK = 8'b1001_1111;

  // mode bit positions
  localparam int MD_ARB    = 0;
  localparam int MD_BSYMON = 2;
  localparam int MD_PARIE  = 4;
  localparam int MD_PARCHK = 5;
  localparam int MD_TGT    = 6;

  localparam int TC_W = 4;

  typedef struct packed {
    logic          rst;
    logic          bsy;
    logic          req;
    logic          msg;
    logic          cd;
    logic          io;
    logic          sel;
    logic          dbp;
    logic          atn;
    logic          ack;
    logic [DW-1:0] db;
  } bus_view_t;

  localparam int BUS_W = $bits(bus_view_t);

  // 1 when data plus parity hold an odd number of ones
  function automatic logic parity_ok(input logic [DW-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  // parity bit giving an odd total with d
  function automatic logic parity_gen(input logic [DW-1:0] d);
    return ~(^d);
  endfunction

  function automatic logic phase_hit(input bus_view_t b, input logic [2:0] want);
    return {b.msg, b.cd, b.io} == want;
  endfunction

endpackage

// File: rtl/scsi_bus_sync.sv
module scsi_bus_sync #(
  parameter int W      = 18,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/scsi_arb_ctl.sv
module scsi_arb_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic arb_en,
  input  logic bus_bsy,
  input  logic bus_sel,
  input  logic own_sel,
  output logic in_prog,
  output logic lost
);

  logic win_evt;
  logic lose_evt;

  assign win_evt  = arb_en & ~in_prog & ~bus_bsy;
  assign lose_evt = arb_en & in_prog & bus_sel & ~own_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_prog <= 1'b0;
      lost    <= 1'b0;
    end else if (!arb_en) begin
      in_prog <= 1'b0;
      lost    <= 1'b0;
    end else begin
      if (win_evt)  in_prog <= 1'b1;
      if (lose_evt) lost    <= 1'b1;
    end
  end

  assert_win_needs_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_prog) |-> ($past(arb_en) && !$past(bus_bsy)));

  assert_lost_implies_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> in_prog);

endmodule

// File: rtl/scsi_irq_ctl.sv
module scsi_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sel_evt,
  input  logic bsy_evt,
  input  logic par_evt,
  input  logic par_ie,
  output logic irq,
  output logic busy_err,
  output logic par_err
);

  logic irq_set;
  assign irq_set = sel_evt | bsy_evt | (par_evt & par_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      busy_err <= 1'b0;
      par_err  <= 1'b0;
    end else begin
      irq      <= irq_set | (irq & ~clr);
      busy_err <= bsy_evt | (busy_err & ~clr);
      par_err  <= par_evt | (par_err & ~clr);
    end
  end

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !irq_set) |=> !irq);

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_set));

  assert_busy_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_evt |=> (busy_err && irq));

endmodule

// File: rtl/scsi_ini_regcore.sv
module scsi_ini_regcore
  import scsi_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          irq,
  input  logic          bus_rst_i,
  input  logic          bus_bsy_i,
  input  logic          bus_sel_i,
  input  logic          bus_atn_i,
  input  logic          bus_ack_i,
  input  logic          bus_req_i,
  input  logic          bus_msg_i,
  input  logic          bus_cd_i,
  input  logic          bus_io_i,
  input  logic [DW-1:0] bus_db_i,
  input  logic          bus_dbp_i,
  output logic          drv_rst_o,
  output logic          drv_bsy_o,
  output logic          drv_sel_o,
  output logic          drv_atn_o,
  output logic          drv_ack_o,
  output logic          drv_req_o,
  output logic          drv_msg_o,
  output logic          drv_cd_o,
  output logic          drv_io_o,
  output logic [DW-1:0] drv_db_o,
  output logic          drv_dbp_o,
  output logic          drv_db_en_o
);

  // ---------------- synchronized bus view ----------------
  bus_view_t        raw_v;
  bus_view_t        sv;
  logic [BUS_W-1:0] sv_bits;

  assign raw_v = {bus_rst_i, bus_bsy_i, bus_req_i, bus_msg_i, bus_cd_i, bus_io_i,
                  bus_sel_i, bus_dbp_i, bus_atn_i, bus_ack_i, bus_db_i};

  scsi_bus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_v),
    .q_o   (sv_bits)
  );
  assign sv = bus_view_t'(sv_bits);

  // ---------------- host registers ----------------
  logic [DW-1:0]   odr_q;
  logic [DW-1:0]   icmd_q;
  logic [DW-1:0]   mode_q;
  logic [TC_W-1:0] tcmd_q;
  logic [DW-1:0]   selen_q;
  logic [DW-1:0]   idr_q;
  logic            bsy_d_q, req_d_q, ack_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odr_q   <= '0;
      icmd_q  <= '0;
      mode_q  <= '0;
      tcmd_q  <= '0;
      selen_q <= '0;
    end else if (cpu_wr) begin
      case (cpu_addr)
        ADR_DATA: odr_q   <= cpu_wdata;
        ADR_ICMD: icmd_q  <= cpu_wdata & IC_STORE_MASK;
        ADR_MODE: mode_q  <= cpu_wdata;
        ADR_TCMD: tcmd_q  <= cpu_wdata[TC_W-1:0];
        ADR_STAT: selen_q <= cpu_wdata;
        default: ;
      endcase
    end
  end

  // ---------------- event detection (named for assertions) ----------------
  logic latch_evt, par_evt, bsy_evt, sel_evt, clr_evt, phase_match;

  assign latch_evt   = mode_q[MD_TGT] ? (ack_d_q & ~sv.ack) : (req_d_q & ~sv.req);
  assign par_evt     = latch_evt & mode_q[MD_PARCHK] & ~parity_ok(sv.db, sv.dbp);
  assign bsy_evt     = mode_q[MD_BSYMON] & bsy_d_q & ~sv.bsy;
  assign sel_evt     = ~sv.bsy & sv.sel & (|(sv.db & selen_q));
  assign clr_evt     = cpu_rd & (cpu_addr == ADR_CLRI);
  assign phase_match = phase_hit(sv, tcmd_q[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idr_q   <= '0;
      bsy_d_q <= 1'b0;
      req_d_q <= 1'b0;
      ack_d_q <= 1'b0;
    end else begin
      if (latch_evt) idr_q <= sv.db;
      bsy_d_q <= sv.bsy;
      req_d_q <= sv.req;
      ack_d_q <= sv.ack;
    end
  end

  // ---------------- arbitration and interrupt ----------------
  logic arb_prog, arb_lost, busy_err, par_err;

  scsi_arb_ctl u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .arb_en  (mode_q[MD_ARB]),
    .bus_bsy (sv.bsy),
    .bus_sel (sv.sel),
    .own_sel (icmd_q[IC_SEL]),
    .in_prog (arb_prog),
    .lost    (arb_lost)
  );

  scsi_irq_ctl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_evt),
    .sel_evt  (sel_evt),
    .bsy_evt  (bsy_evt),
    .par_evt  (par_evt),
    .par_ie   (mode_q[MD_PARIE]),
    .irq      (irq),
    .busy_err (busy_err),
    .par_err  (par_err)
  );

  // ---------------- read mux ----------------
  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      ADR_DATA:  cpu_rdata = sv.db;
      ADR_ICMD: begin
        cpu_rdata          = icmd_q;
        cpu_rdata[IC_PROG] = arb_prog;
        cpu_rdata[IC_LOST] = arb_lost;
      end
      ADR_MODE:  cpu_rdata = mode_q;
      ADR_TCMD:  cpu_rdata = {{(DW-TC_W){1'b0}}, tcmd_q};
      ADR_STAT:  cpu_rdata = {sv.rst, sv.bsy, sv.req, sv.msg, sv.cd, sv.io, sv.sel, sv.dbp};
      ADR_BSTAT: cpu_rdata = {2'b00, par_err, irq, phase_match, busy_err, sv.atn, sv.ack};
      ADR_IDATA: cpu_rdata = idr_q;
      default:   cpu_rdata = '0;
    endcase
  end

  // ---------------- bus drive ----------------
  assign drv_rst_o   = icmd_q[IC_RST];
  assign drv_ack_o   = icmd_q[IC_ACK];
  assign drv_sel_o   = icmd_q[IC_SEL];
  assign drv_atn_o   = icmd_q[IC_ATN];
  assign drv_bsy_o   = icmd_q[IC_BSY] | arb_prog;
  assign drv_req_o   = mode_q[MD_TGT] & tcmd_q[3];
  assign drv_msg_o   = mode_q[MD_TGT] & tcmd_q[2];
  assign drv_cd_o    = mode_q[MD_TGT] & tcmd_q[1];
  assign drv_io_o    = mode_q[MD_TGT] & tcmd_q[0];
  assign drv_db_o    = odr_q;
  assign drv_dbp_o   = parity_gen(odr_q);
  assign drv_db_en_o = mode_q[MD_ARB] | (icmd_q[IC_DATA] & phase_match);

  assert_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> (idr_q == $past(sv.db)));

endmodule

// File: tb/test_scsi_ini_regcore.sv
module test_scsi_ini_regcore;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       irq;
  logic [17:0] b_raw = '0; // {rst,bsy,req,msg,cd,io,sel,dbp,atn,ack,db[7:0]}
  logic       drv_rst, drv_bsy, drv_sel, drv_atn, drv_ack;
  logic       drv_req, drv_msg, drv_cd, drv_io, drv_dbp, drv_db_en;
  logic [7:0] drv_db;

  always #4 clk = ~clk;

  scsi_ini_regcore i_scsi_ini_regcore (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
    .bus_rst_i(b_raw[17]), .bus_bsy_i(b_raw[16]), .bus_sel_i(b_raw[11]),
    .bus_atn_i(b_raw[9]), .bus_ack_i(b_raw[8]), .bus_req_i(b_raw[15]),
    .bus_msg_i(b_raw[14]), .bus_cd_i(b_raw[13]), .bus_io_i(b_raw[12]),
    .bus_db_i(b_raw[7:0]), .bus_dbp_i(b_raw[10]),
    .drv_rst_o(drv_rst), .drv_bsy_o(drv_bsy), .drv_sel_o(drv_sel), .drv_atn_o(drv_atn),
    .drv_ack_o(drv_ack), .drv_req_o(drv_req), .drv_msg_o(drv_msg), .drv_cd_o(drv_cd),
    .drv_io_o(drv_io), .drv_db_o(drv_db), .drv_dbp_o(drv_dbp), .drv_db_en_o(drv_db_en)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [17:0] pipe[$] = '{18'd0, 18'd0};
  logic [7:0]  m_odr = 0, m_icr = 0, m_mode = 0, m_ser = 0, m_idr = 0;
  logic [3:0]  m_tcr = 0;
  bit m_aip = 0, m_la = 0, m_irq = 0, m_berr = 0, m_perr = 0;
  bit m_pbsy = 0, m_preq = 0, m_pack = 0;
  logic [17:0] ms;
  bit mlatch, mpe, mbe, mse, mclr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_odr = 0; m_icr = 0; m_mode = 0; m_ser = 0; m_idr = 0; m_tcr = 0;
      m_aip = 0; m_la = 0; m_irq = 0; m_berr = 0; m_perr = 0;
      m_pbsy = 0; m_preq = 0; m_pack = 0;
      pipe = '{18'd0, 18'd0};
    end else begin
      ms     = pipe[0];
      mlatch = m_mode[6] ? (m_pack && !ms[8]) : (m_preq && !ms[15]);
      mpe    = mlatch && m_mode[5] && (($countones(ms[7:0]) + int'(ms[10])) % 2 == 0);
      mbe    = m_mode[2] && m_pbsy && !ms[16];
      mse    = !ms[16] && ms[11] && ((ms[7:0] & m_ser) != 0);
      mclr   = cpu_rd && (cpu_addr == 3'd7);
      m_irq  = mse || mbe || (mpe && m_mode[4]) || (m_irq && !mclr);
      m_berr = mbe || (m_berr && !mclr);
      m_perr = mpe || (m_perr && !mclr);
      if (!m_mode[0]) begin
        m_aip = 0; m_la = 0;
      end else begin
        m_la  = m_la || (m_aip && ms[11] && !m_icr[2]);
        m_aip = m_aip || !ms[16];
      end
      if (mlatch) m_idr = ms[7:0];
      if (cpu_wr) begin
        case (cpu_addr)
          3'd0: m_odr = cpu_wdata;
          3'd1: m_icr = cpu_wdata & 8'h9F;
          3'd2: m_mode = cpu_wdata;
          3'd3: m_tcr = cpu_wdata[3:0];
          3'd4: m_ser = cpu_wdata;
          default: ;
        endcase
      end
      m_pbsy = ms[16]; m_preq = ms[15]; m_pack = ms[8];
      pipe.push_back(b_raw);
      void'(pipe.pop_front());
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    logic [17:0] s;
    logic pm;
    s  = pipe[0];
    pm = (s[14:12] == m_tcr[2:0]);
    case (a)
      3'd0: return s[7:0];
      3'd1: return m_icr | {1'b0, m_aip, m_la, 5'b0};
      3'd2: return m_mode;
      3'd3: return {4'b0, m_tcr};
      3'd4: return s[17:10];
      3'd5: return {2'b0, m_perr, m_irq, pm, m_berr, s[9], s[8]};
      3'd6: return m_idr;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0, 3'd4: return "R3 bus view read";
      3'd1, 3'd2, 3'd3: return "R2 register readback";
      3'd5: return "R4 bus-and-status read";
      3'd6: return "R8 captured byte";
      default: return "R12 clear address reads zero";
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(cpu_rdata, exp_rd(cpu_addr), rd_tag(cpu_addr));
      check({7'b0, irq}, {7'b0, m_irq}, "R10 R11 R12 interrupt pin");
      check({4'b0, drv_rst, drv_ack, drv_sel, drv_atn},
            {4'b0, m_icr[7], m_icr[4], m_icr[2], m_icr[1]}, "R5 initiator asserts");
      check({4'b0, drv_req, drv_msg, drv_cd, drv_io},
            m_mode[6] ? {4'b0, m_tcr} : 8'h00, "R5 target asserts");
      check({7'b0, drv_bsy}, {7'b0, m_icr[3] | m_aip}, "R7 BSY drive");
      check(drv_db, m_odr, "R6 data out");
      check({7'b0, drv_dbp}, {7'b0, ($countones(m_odr) % 2 == 0)}, "R6 parity out");
      check({7'b0, drv_db_en},
            {7'b0, m_mode[0] | (m_icr[0] & (pipe[0][14:12] == m_tcr[2:0]))}, "R6 data enable");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    #2;
    check(cpu_rdata, exp, tag);
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic set_bus(input logic [17:0] v);
    @(negedge clk);
    b_raw = v;
    repeat (3) @(negedge clk);
  endtask

  // bus vector builder: {rst,bsy,req,msg,cd,io,sel,dbp,atn,ack,db}
  function automatic logic [17:0] bv(input bit rst, bsy, req, msg, cd, io, sel, dbp,
                                     atn, ack, input logic [7:0] db);
    return {rst, bsy, req, msg, cd, io, sel, dbp, atn, ack, db};
  endfunction

  task automatic irq_expect(input bit e, input string tag);
    @(negedge clk);
    #2;
    check({7'b0, irq}, {7'b0, e}, tag);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'h5C51));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_expect(3'd1, 8'h00, "R1 reset command");
    rd_expect(3'd2, 8'h00, "R1 reset mode");
    rd_expect(3'd3, 8'h00, "R1 reset target command");
    rd_expect(3'd5, 8'h08, "R1 reset flags (idle phase matches)");
    rd_expect(3'd6, 8'h00, "R1 reset captured byte");
    irq_expect(1'b0, "R1 reset interrupt");

    // R2 writes and readback, dropped bits and ignored addresses
    wr(3'd0, 8'hA5);
    wr(3'd1, 8'hFF);
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'h0F);
    rd_expect(3'd1, 8'h9F, "R2 command bits 6..5 dropped");
    rd_expect(3'd3, 8'h0F, "R2 target command upper bits zero");
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd_expect(3'd1, 8'h9F, "R2 writes to 5..7 ignored");
    rd_expect(3'd2, 8'h00, "R2 mode untouched by 5..7");
    wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);

    // R3 bus view through synchronizer
    set_bus(bv(1, 0, 0, 1, 0, 1, 0, 1, 0, 0, 8'h3C));
    rd_expect(3'd0, 8'h3C, "R3 data lines");
    rd_expect(3'd4, 8'h95, "R3 status order");

    // R4/R6 phase match and data enable
    wr(3'd3, 8'h05);
    rd_expect(3'd5, 8'h08, "R4 phase match set");
    wr(3'd1, 8'h01);
    @(negedge clk); #2;
    check({7'b0, drv_db_en}, 8'h01, "R6 enable on match");
    check({7'b0, drv_dbp}, 8'h01, "R6 odd parity for A5");
    wr(3'd3, 8'h00);
    @(negedge clk); #2;
    check({7'b0, drv_db_en}, 8'h00, "R6 enable drops on mismatch");
    wr(3'd1, 8'h00);
    set_bus('0);

    // R5 target outputs
    wr(3'd3, 8'h0B);
    wr(3'd2, 8'h40);
    @(negedge clk); #2;
    check({4'b0, drv_req, drv_msg, drv_cd, drv_io}, 8'h0B, "R5 target lines follow");
    wr(3'd2, 8'h00);
    @(negedge clk); #2;
    check({4'b0, drv_req, drv_msg, drv_cd, drv_io}, 8'h00, "R5 initiator keeps target lines off");
    wr(3'd3, 8'h00);

    // R7 arbitration
    set_bus(bv(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00));
    wr(3'd2, 8'h01);
    repeat (3) @(negedge clk);
    rd_expect(3'd1, 8'h00, "R7 no progress while bus busy");
    set_bus('0);
    rd_expect(3'd1, 8'h40, "R7 progress once bus free");
    check({7'b0, drv_bsy}, 8'h01, "R7 BSY asserted while arbitrating");
    set_bus(bv(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 8'h00));
    rd_expect(3'd1, 8'h60, "R7 lost on foreign SEL");
    wr(3'd2, 8'h00);
    rd_expect(3'd1, 8'h00, "R7 flags clear with mode bit 0");
    set_bus('0);

    // R8 capture on REQ fall (initiator) and ACK fall (target)
    set_bus(bv(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 8'h5A));
    set_bus(bv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h5A));
    rd_expect(3'd6, 8'h5A, "R8 capture on REQ fall");
    wr(3'd2, 8'h40);
    set_bus(bv(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 8'h77));
    set_bus(bv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h77));
    rd_expect(3'd6, 8'h5A, "R8 REQ fall ignored in target mode");
    set_bus(bv(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h11));
    set_bus(bv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h11));
    rd_expect(3'd6, 8'h11, "R8 capture on ACK fall");
    wr(3'd2, 8'h00);

    // R9 parity error with interrupt enabled, R12 clear
    wr(3'd2, 8'h30);
    set_bus(bv(0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 8'h5A));
    set_bus(bv(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h5A));
    rd_expect(3'd5, 8'h08, "R9 good parity no error");
    set_bus(bv(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 8'h5A));
    set_bus(bv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h5A));
    rd_expect(3'd5, 8'h38, "R9 bad parity flag and interrupt");
    rd_expect(3'd7, 8'h00, "R12 clear read returns zero");
    rd_expect(3'd5, 8'h08, "R12 flags cleared");
    irq_expect(1'b0, "R12 interrupt cleared");
    wr(3'd2, 8'h00);

    // R10 selection interrupt, set wins over clear
    wr(3'd4, 8'h0F);
    set_bus(bv(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 8'h04));
    irq_expect(1'b1, "R10 selection raises interrupt");
    rd_expect(3'd7, 8'h00, "R12 clear during active condition");
    irq_expect(1'b1, "R12 new event beats clear");
    set_bus(bv(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 8'hF0));
    rd_expect(3'd7, 8'h00, "R10 clear with masked id");
    irq_expect(1'b0, "R10 masked data line gives no interrupt");
    wr(3'd4, 8'h00);
    set_bus('0);

    // R11 busy loss
    wr(3'd2, 8'h04);
    set_bus(bv(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00));
    set_bus('0);
    rd_expect(3'd5, 8'h1C, "R11 busy error and interrupt");
    rd_expect(3'd7, 8'h00, "R11 clear");
    wr(3'd2, 8'h00);

    // random traffic, checked every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      b_raw     = 18'($urandom);
      cpu_addr  = 3'($urandom_range(0, 7));
      cpu_wdata = 8'($urandom);
      case ($urandom_range(0, 3))
        0: begin cpu_wr = 1'b1; cpu_rd = 1'b0; end
        1: begin cpu_wr = 1'b0; cpu_rd = 1'b1; end
        default: begin cpu_wr = 1'b0; cpu_rd = 1'b0; end
      endcase
    end
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule